// File: doc/BRIEF.md
# Stream-to-Memory DMA Channel

This block moves one packet from an AXI4-Stream input into system memory through an AXI4 write master. Software programs it through an AXI4-Lite slave. It sets the run bit, optionally enables the completion and error interrupts, writes a destination address, and finally writes a buffer capacity in bytes. That last write arms the channel. Stream beats are then accepted and written to memory at consecutive addresses, starting at the destination.

The capacity is an upper bound, not an exact count. The packet ends at TLAST. Once every stored byte has been acknowledged by memory, the length register reads back the number of bytes actually stored and the done status bit is set. Beats that would fall beyond the capacity are still accepted up to TLAST, but they are dropped and the overflow error bit is raised.

Internally, beats are staged in a FIFO one maximum burst deep. A write burst is issued only when a full burst is staged or TLAST has arrived. Bursts are trimmed so that none crosses a 4 KB page.

Top module: `s2mm_dma`

## Requirements
- R1: After reset the status register reads 0x1 (halted bit 0 set, busy bit 1 clear, done bit 4 clear, error bit 5 clear). The stream ready output, the memory address valid output and both interrupt outputs are low.
- R2: Control register offset 0x0 has run at bit 0, done interrupt enable at bit 1 and error interrupt enable at bit 2. The halted status bit reads as the inverse of the run bit.
- R3: A write to the length register (offset 0xC) arms the channel and sets busy only if the value is non-zero, run is 1 and the channel is not already busy. A zero value, or any length write while busy, changes neither the armed state nor the capacity in force.
- R4: Stream ready is high only while the channel is running, armed and has not yet seen TLAST. It drops after TLAST and stays low until the channel is re-armed.
- R5: Stored bytes are written at consecutive addresses starting at the destination address (offset 0x8). The low log2(DATA_W/8) address bits are forced to zero. Every burst address is aligned to the data width.
- R6: Each write burst is INCR type, carries at most MAX_BURST beats, never crosses a 4 KB boundary, and asserts WLAST on exactly beat AWLEN+1.
- R7: Write strobes follow TKEEP. On the last beat inside the capacity, strobes are additionally limited to the bytes that still fit. Bytes outside the strobes are left untouched in memory.
- R8: After TLAST, once all bursts have been acknowledged, done (status bit 4) is set, busy clears, and the length register reads the number of bytes stored.
- R9: Beats beyond the capacity are accepted up to TLAST and discarded, nothing is written beyond the buffer, and error status bit 5 is set.
- R10: The done and error interrupt outputs equal their status bit ANDed with their own enable. Writing 1 to status bit 4 or bit 5 clears that bit, but a clear that coincides with a new set leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_awaddr_i | input | 4 | Register write address |
| cfg_awvalid_i | input | 1 | Register write address valid |
| cfg_awready_o | output | 1 | Register write address ready |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_wvalid_i | input | 1 | Register write data valid |
| cfg_wready_o | output | 1 | Register write data ready |
| cfg_bresp_o | output | 2 | Register write response (always OKAY) |
| cfg_bvalid_o | output | 1 | Register write response valid |
| cfg_bready_i | input | 1 | Register write response ready |
| cfg_araddr_i | input | 4 | Register read address |
| cfg_arvalid_i | input | 1 | Register read address valid |
| cfg_arready_o | output | 1 | Register read address ready |
| cfg_rdata_o | output | 32 | Register read data |
| cfg_rresp_o | output | 2 | Register read response (always OKAY) |
| cfg_rvalid_o | output | 1 | Register read data valid |
| cfg_rready_i | input | 1 | Register read data ready |
| rx_tdata_i | input | DATA_W | Stream data |
| rx_tkeep_i | input | DATA_W/8 | Stream byte qualifiers |
| rx_tlast_i | input | 1 | Stream end of packet |
| rx_tvalid_i | input | 1 | Stream valid |
| rx_tready_o | output | 1 | Stream ready |
| mem_awaddr_o | output | ADDR_W | Burst start address |
| mem_awlen_o | output | 8 | Burst length minus one |
| mem_awsize_o | output | 3 | Beat size code |
| mem_awburst_o | output | 2 | Burst type (INCR) |
| mem_awvalid_o | output | 1 | Address valid |
| mem_awready_i | input | 1 | Address ready |
| mem_wdata_o | output | DATA_W | Write data |
| mem_wstrb_o | output | DATA_W/8 | Write strobes |
| mem_wlast_o | output | 1 | Last beat of burst |
| mem_wvalid_o | output | 1 | Write data valid |
| mem_wready_i | input | 1 | Write data ready |
| mem_bvalid_i | input | 1 | Write response valid |
| mem_bready_o | output | 1 | Write response ready |
| done_irq_o | output | 1 | Completion interrupt |
| err_irq_o | output | 1 | Overflow error interrupt |

## Verification
Two events can hit the error status bit in the same clock: overflow detection on a discarded beat, and a software write-one-to-clear of that bit. The bench arms a one-beat buffer and sends one kept beat. On a single edge it then presents both the discarded TLAST beat and a status write clearing bit 5, after confirming that both ready signals are high. The error bit must still read 1 afterwards, and a later clear on its own must bring it to 0.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;
  localparam int CSR_AW = 4;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DST  = 2'd2;
  localparam logic [1:0] REG_LEN  = 2'd3;
  localparam int ST_DONE = 4;
  localparam int ST_ERR  = 5;
  typedef enum logic [1:0] {WR_IDLE, WR_ADDR, WR_DATA, WR_RESP} wr_state_e;
endpackage

// File: rtl/s2mm_fifo.sv
module s2mm_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [AW:0]   count_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;
  assign full_o  = cnt_q == (AW+1)'(DEPTH);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + AW'(1);
      if (pop_i)  rp_q <= rp_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/s2mm_csr.sv
module s2mm_csr import s2mm_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSR_AW-1:0] cfg_awaddr_i,
  input  logic              cfg_awvalid_i,
  output logic              cfg_awready_o,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              cfg_wvalid_i,
  output logic              cfg_wready_o,
  output logic              cfg_bvalid_o,
  input  logic              cfg_bready_i,
  input  logic [CSR_AW-1:0] cfg_araddr_i,
  input  logic              cfg_arvalid_i,
  output logic              cfg_arready_o,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_rvalid_o,
  input  logic              cfg_rready_i,
  input  logic              done_i,
  input  logic              ovf_i,
  input  logic [LEN_W-1:0]  rx_bytes_i,
  output logic              run_o,
  output logic              armed_o,
  output logic              arm_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [LEN_W-1:0]  cap_o,
  output logic              done_irq_o,
  output logic              err_irq_o
);
  logic run_q, done_ie_q, err_ie_q, armed_q, done_q, err_q, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0] dst_q;
  logic [LEN_W-1:0]  len_q;
  logic [31:0]       rdata_q;
  logic wr_en, rd_en, wr_ok, stat_wr;

  assign wr_en   = cfg_awvalid_i & cfg_wvalid_i & ~bvalid_q;
  assign wr_ok   = wr_en & (cfg_awaddr_i[1:0] == 2'b00);
  assign stat_wr = wr_ok & (cfg_awaddr_i[3:2] == REG_STAT);
  assign arm_o   = wr_ok & (cfg_awaddr_i[3:2] == REG_LEN) & run_q & ~armed_q
                 & (cfg_wdata_i[LEN_W-1:0] != '0);
  assign rd_en   = cfg_arvalid_i & ~rvalid_q;

  assign cfg_awready_o = wr_en;
  assign cfg_wready_o  = wr_en;
  assign cfg_bvalid_o  = bvalid_q;
  assign cfg_arready_o = ~rvalid_q;
  assign cfg_rvalid_o  = rvalid_q;
  assign cfg_rdata_o   = rdata_q;

  assign run_o      = run_q;
  assign armed_o    = armed_q;
  assign dst_o      = dst_q;
  assign cap_o      = len_q;
  assign done_irq_o = done_q & done_ie_q;
  assign err_irq_o  = err_q & err_ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; done_ie_q <= 1'b0; err_ie_q <= 1'b0;
      armed_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      dst_q <= '0; len_q <= '0;
      bvalid_q <= 1'b0; rvalid_q <= 1'b0; rdata_q <= '0;
    end else begin
      if (wr_en) bvalid_q <= 1'b1;
      else if (cfg_bready_i) bvalid_q <= 1'b0;
      if (wr_ok && cfg_awaddr_i[3:2] == REG_CTRL) begin
        run_q     <= cfg_wdata_i[0];
        done_ie_q <= cfg_wdata_i[1];
        err_ie_q  <= cfg_wdata_i[2];
      end
      if (wr_ok && cfg_awaddr_i[3:2] == REG_DST)
        dst_q <= {cfg_wdata_i[ADDR_W-1:OFF_W], OFF_W'(0)};
      // set beats clear when both land in one cycle
      if (done_i) done_q <= 1'b1;
      else if (stat_wr && cfg_wdata_i[ST_DONE]) done_q <= 1'b0;
      if (ovf_i) err_q <= 1'b1;
      else if (stat_wr && cfg_wdata_i[ST_ERR]) err_q <= 1'b0;
      if (arm_o) begin
        armed_q <= 1'b1;
        len_q   <= cfg_wdata_i[LEN_W-1:0];
      end else if (done_i) begin
        armed_q <= 1'b0;
        len_q   <= rx_bytes_i;
      end
      if (rd_en) begin
        rvalid_q <= 1'b1;
        if (cfg_araddr_i[1:0] != 2'b00) rdata_q <= '0;
        else begin
          case (cfg_araddr_i[3:2])
            REG_CTRL: rdata_q <= 32'({err_ie_q, done_ie_q, run_q});
            REG_STAT: rdata_q <= 32'({err_q, done_q, 2'b00, armed_q, ~run_q});
            REG_DST:  rdata_q <= 32'(dst_q);
            default:  rdata_q <= 32'(len_q);
          endcase
        end
      end else if (cfg_rready_i) rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/s2mm_writer.sv
module s2mm_writer import s2mm_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 16,
  localparam int BYTES    = DATA_W / 8,
  localparam int OFF_W    = $clog2(BYTES),
  localparam int CNT_W    = $clog2(MAX_BURST) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              closed_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  output logic              fifo_pop_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_awaddr_o,
  output logic [7:0]        mem_awlen_o,
  output logic              mem_awvalid_o,
  input  logic              mem_awready_i,
  output logic              mem_wlast_o,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  input  logic              mem_bvalid_i,
  output logic              mem_bready_o
);
  wr_state_e         state_q;
  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  blen_q, wcnt_q, limit, blen_d;
  logic [12:0]       room_bytes, room_beats;
  logic              full_burst, issue;

  // beats left before the next 4 KB page
  assign room_bytes = 13'd4096 - {1'b0, addr_q[11:0]};
  assign room_beats = room_bytes >> OFF_W;
  assign limit      = (room_beats < 13'(MAX_BURST)) ? room_beats[CNT_W-1:0] : CNT_W'(MAX_BURST);
  assign full_burst = fifo_cnt_i >= limit;
  assign blen_d     = full_burst ? limit : fifo_cnt_i;
  assign issue      = (state_q == WR_IDLE) & active_q & (full_burst | (closed_i & (fifo_cnt_i != '0)));
  assign done_o     = (state_q == WR_IDLE) & active_q & closed_i & (fifo_cnt_i == '0);

  assign mem_awaddr_o  = addr_q;
  assign mem_awlen_o   = 8'(blen_q - CNT_W'(1));
  assign mem_awvalid_o = state_q == WR_ADDR;
  assign mem_wvalid_o  = state_q == WR_DATA;
  assign mem_wlast_o   = wcnt_q == blen_q - CNT_W'(1);
  assign mem_bready_o  = state_q == WR_RESP;
  assign fifo_pop_o    = mem_wvalid_o & mem_wready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WR_IDLE;
      active_q <= 1'b0;
      addr_q   <= '0;
      blen_q   <= '0;
      wcnt_q   <= '0;
    end else begin
      if (arm_i) begin
        active_q <= 1'b1;
        addr_q   <= base_i;
      end else if (done_o) active_q <= 1'b0;
      case (state_q)
        WR_IDLE: if (issue) begin
          blen_q  <= blen_d;
          wcnt_q  <= '0;
          state_q <= WR_ADDR;
        end
        WR_ADDR: if (mem_awready_i) state_q <= WR_DATA;
        WR_DATA: if (mem_wready_i) begin
          wcnt_q <= wcnt_q + CNT_W'(1);
          if (mem_wlast_o) state_q <= WR_RESP;
        end
        default: if (mem_bvalid_i) begin
          addr_q  <= addr_q + (ADDR_W'(blen_q) << OFF_W);
          state_q <= WR_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/s2mm_dma.sv
module s2mm_dma import s2mm_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16,
  localparam int BYTES    = DATA_W / 8,
  localparam int OFF_W    = $clog2(BYTES),
  localparam int CNT_W    = $clog2(MAX_BURST) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSR_AW-1:0] cfg_awaddr_i,
  input  logic              cfg_awvalid_i,
  output logic              cfg_awready_o,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              cfg_wvalid_i,
  output logic              cfg_wready_o,
  output logic [1:0]        cfg_bresp_o,
  output logic              cfg_bvalid_o,
  input  logic              cfg_bready_i,
  input  logic [CSR_AW-1:0] cfg_araddr_i,
  input  logic              cfg_arvalid_i,
  output logic              cfg_arready_o,
  output logic [31:0]       cfg_rdata_o,
  output logic [1:0]        cfg_rresp_o,
  output logic              cfg_rvalid_o,
  input  logic              cfg_rready_i,
  input  logic [DATA_W-1:0] rx_tdata_i,
  input  logic [BYTES-1:0]  rx_tkeep_i,
  input  logic              rx_tlast_i,
  input  logic              rx_tvalid_i,
  output logic              rx_tready_o,
  output logic [ADDR_W-1:0] mem_awaddr_o,
  output logic [7:0]        mem_awlen_o,
  output logic [2:0]        mem_awsize_o,
  output logic [1:0]        mem_awburst_o,
  output logic              mem_awvalid_o,
  input  logic              mem_awready_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BYTES-1:0]  mem_wstrb_o,
  output logic              mem_wlast_o,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  input  logic              mem_bvalid_i,
  output logic              mem_bready_o,
  output logic              done_irq_o,
  output logic              err_irq_o
);
  logic              run, armed, arm, done_pulse, ovf_pulse;
  logic [ADDR_W-1:0] dst;
  logic [LEN_W-1:0]  cap, bytes_q;
  logic [LEN_W:0]    cap_beats, beat_q, tail;
  logic [BYTES-1:0]  cap_mask, keep_strb;
  logic              closed_q, keep_beat, last_in_buf, accept, push, pop, fifo_full;
  logic [CNT_W-1:0]  fifo_cnt;

  assign cfg_bresp_o   = 2'b00;
  assign cfg_rresp_o   = 2'b00;
  assign mem_awsize_o  = 3'(OFF_W);
  assign mem_awburst_o = 2'b01;

  s2mm_csr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_csr (
    .clk_i, .rst_ni,
    .cfg_awaddr_i, .cfg_awvalid_i, .cfg_awready_o, .cfg_wdata_i, .cfg_wvalid_i,
    .cfg_wready_o, .cfg_bvalid_o, .cfg_bready_i, .cfg_araddr_i, .cfg_arvalid_i,
    .cfg_arready_o, .cfg_rdata_o, .cfg_rvalid_o, .cfg_rready_i,
    .done_i(done_pulse), .ovf_i(ovf_pulse), .rx_bytes_i(bytes_q),
    .run_o(run), .armed_o(armed), .arm_o(arm), .dst_o(dst), .cap_o(cap),
    .done_irq_o, .err_irq_o
  );

  // capacity in beats, and byte budget of the final in-buffer beat
  assign cap_beats   = ({1'b0, cap} + (LEN_W+1)'(BYTES - 1)) >> OFF_W;
  assign keep_beat   = beat_q < cap_beats;
  assign last_in_buf = beat_q == cap_beats - (LEN_W+1)'(1);
  assign tail        = {1'b0, cap} - (beat_q << OFF_W);

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      cap_mask[i] = ~last_in_buf | (tail > (LEN_W+1)'(i));
  end

  assign keep_strb   = rx_tkeep_i & cap_mask;
  assign rx_tready_o = run & armed & ~closed_q & (~keep_beat | ~fifo_full);
  assign accept      = rx_tvalid_i & rx_tready_o;
  assign push        = accept & keep_beat;
  assign ovf_pulse   = accept & (~keep_beat | (|(rx_tkeep_i & ~cap_mask)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q   <= '0;
      bytes_q  <= '0;
      closed_q <= 1'b0;
    end else if (arm) begin
      beat_q   <= '0;
      bytes_q  <= '0;
      closed_q <= 1'b0;
    end else if (accept) begin
      if (keep_beat) begin
        beat_q  <= beat_q + (LEN_W+1)'(1);
        bytes_q <= bytes_q + LEN_W'($countones(keep_strb));
      end
      if (rx_tlast_i) closed_q <= 1'b1;
    end
  end

  s2mm_fifo #(.W(DATA_W + BYTES), .DEPTH(MAX_BURST)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .din_i({keep_strb, rx_tdata_i}),
    .pop_i(pop), .dout_o({mem_wstrb_o, mem_wdata_o}),
    .count_o(fifo_cnt), .full_o(fifo_full)
  );

  s2mm_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)) u_writer (
    .clk_i, .rst_ni,
    .arm_i(arm), .base_i(dst), .closed_i(closed_q), .fifo_cnt_i(fifo_cnt),
    .fifo_pop_o(pop), .done_o(done_pulse),
    .mem_awaddr_o, .mem_awlen_o, .mem_awvalid_o, .mem_awready_i,
    .mem_wlast_o, .mem_wvalid_o, .mem_wready_i, .mem_bvalid_i, .mem_bready_o
  );
endmodule

// File: rtl/s2mm_dma_chk.sv
module s2mm_dma_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 16,
  localparam int BYTES    = DATA_W / 8,
  localparam int OFF_W    = $clog2(BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run,
  input logic              armed,
  input logic              closed,
  input logic              done_pulse,
  input logic              tready,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic              awvalid,
  input logic              awready,
  input logic              wvalid,
  input logic [BYTES-1:0]  wstrb
);
  p_tready_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tready |-> (run && armed && !closed));

  p_aw_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

  p_burst_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid |-> (int'(awlen) < MAX_BURST));

  p_no_page_cross_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid |-> ((14'(awaddr[11:0]) + ((14'(awlen) + 14'd1) << OFF_W)) <= 14'd4096));

  p_addr_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid |-> (awaddr[OFF_W-1:0] == '0));

  p_strb_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid |-> (wstrb != '0));

  p_addr_before_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid |-> !awvalid);

  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse |-> (closed && armed));
endmodule

bind s2mm_dma s2mm_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .armed(armed), .closed(closed_q),
  .done_pulse(done_pulse), .tready(rx_tready_o), .awaddr(mem_awaddr_o),
  .awlen(mem_awlen_o), .awvalid(mem_awvalid_o), .awready(mem_awready_i),
  .wvalid(mem_wvalid_o), .wstrb(mem_wstrb_o)
);

// File: tb/tb_s2mm_dma.sv
module tb_s2mm_dma;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int BY = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  cfg_awaddr = '0, cfg_araddr = '0;
  logic        cfg_awvalid = 0, cfg_wvalid = 0, cfg_arvalid = 0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
  logic [1:0]  cfg_bresp, cfg_rresp;
  logic [31:0] cfg_rdata;
  logic [DW-1:0] tdata = '0;
  logic [BY-1:0] tkeep = '0;
  logic        tlast = 0, tvalid = 0, tready;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        awvalid, wlast, wvalid, bready, done_irq, err_irq;
  logic [DW-1:0] wdata;
  logic [BY-1:0] wstrb;
  logic        aw_act = 0, bvalid = 0;

  s2mm_dma dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_awaddr_i(cfg_awaddr), .cfg_awvalid_i(cfg_awvalid), .cfg_awready_o(cfg_awready),
    .cfg_wdata_i(cfg_wdata), .cfg_wvalid_i(cfg_wvalid), .cfg_wready_o(cfg_wready),
    .cfg_bresp_o(cfg_bresp), .cfg_bvalid_o(cfg_bvalid), .cfg_bready_i(1'b1),
    .cfg_araddr_i(cfg_araddr), .cfg_arvalid_i(cfg_arvalid), .cfg_arready_o(cfg_arready),
    .cfg_rdata_o(cfg_rdata), .cfg_rresp_o(cfg_rresp), .cfg_rvalid_o(cfg_rvalid), .cfg_rready_i(1'b1),
    .rx_tdata_i(tdata), .rx_tkeep_i(tkeep), .rx_tlast_i(tlast), .rx_tvalid_i(tvalid), .rx_tready_o(tready),
    .mem_awaddr_o(awaddr), .mem_awlen_o(awlen), .mem_awsize_o(awsize), .mem_awburst_o(awburst),
    .mem_awvalid_o(awvalid), .mem_awready_i(!aw_act),
    .mem_wdata_o(wdata), .mem_wstrb_o(wstrb), .mem_wlast_o(wlast), .mem_wvalid_o(wvalid),
    .mem_wready_i(aw_act), .mem_bvalid_i(bvalid), .mem_bready_o(bready),
    .done_irq_o(done_irq), .err_irq_o(err_irq)
  );

  int n_checks = 0, n_fail = 0, n_bursts = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory slave model with burst monitor
  logic [7:0]  mem [8192];
  logic [31:0] waddr = '0;
  int wbeats = 0, blen = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (awvalid && !aw_act) begin
        aw_act <= 1; waddr <= awaddr; wbeats <= 0; blen <= int'(awlen) + 1;
        n_bursts++;
        chk("R6 burst length/page/type", {31'd0, (int'(awlen) < 16) && ((int'(awaddr[11:0]) + (int'(awlen)+1)*BY) <= 4096)
             && awburst == 2'b01 && awsize == 3'd2}, 32'd1);
      end
      if (wvalid && aw_act) begin
        for (int j = 0; j < BY; j++)
          if (wstrb[j]) mem[(waddr + 32'(j)) & 32'h1FFF] <= wdata[8*j +: 8];
        waddr <= waddr + BY;
        wbeats <= wbeats + 1;
        if (wlast) begin
          chk("R6 wlast position", 32'(wbeats + 1), 32'(blen));
          aw_act <= 0; bvalid <= 1;
        end
      end
      if (bvalid && bready) bvalid <= 0;
    end
  end

  function automatic logic [31:0] word_of(input int id, input int b);
    return {8'hA5, 8'(id), 16'(b)};
  endfunction

  task automatic lite_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_awaddr = a; cfg_wdata = d; cfg_awvalid = 1; cfg_wvalid = 1;
    #1;
    while (!cfg_awready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cfg_awvalid = 0; cfg_wvalid = 0;
  endtask

  task automatic lite_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_araddr = a; cfg_arvalid = 1;
    #1;
    while (!cfg_arready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cfg_arvalid = 0;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic send_beat(input logic [31:0] d, input logic [3:0] k, input logic l);
    @(negedge clk);
    tdata = d; tkeep = k; tlast = l; tvalid = 1;
    #1;
    while (!tready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    tvalid = 0; tlast = 0;
  endtask

  task automatic send_pkt(input int id, input int nb, input logic [3:0] last_keep);
    for (int b = 0; b < nb; b++)
      send_beat(word_of(id, b), (b == nb-1) ? last_keep : 4'hF, b == nb-1);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      lite_rd(4'h4, s);
      if (s[4]) return;
    end
  endtask

  task automatic check_mem(input string req, input int base, input int nbytes, input int id);
    int bad = 0;
    logic [7:0] first_act = 0, first_exp = 0;
    for (int j = 0; j < nbytes; j++) begin
      logic [7:0] e;
      e = 8'(word_of(id, j / BY) >> (8 * (j % BY)));
      if (mem[base + j] !== e) begin
        if (bad == 0) begin first_act = mem[base + j]; first_exp = e; end
        bad++;
      end
    end
    chk(req, {24'd0, first_act}, {24'd0, first_exp});
  endtask

  task automatic t_reset();
    logic [31:0] s;
    @(negedge clk);
    chk("R1 tready at reset", {31'd0, tready}, 32'd0);
    chk("R1 awvalid at reset", {31'd0, awvalid}, 32'd0);
    chk("R1 irqs at reset", {30'd0, done_irq, err_irq}, 32'd0);
    lite_rd(4'h4, s);
    chk("R1 status at reset", s, 32'h1);
  endtask

  task automatic t_run_and_zero_len();
    logic [31:0] s;
    lite_wr(4'h0, 32'h1);
    lite_rd(4'h4, s);
    chk("R2 halted clears with run", s, 32'h0);
    lite_wr(4'hC, 32'h0);
    lite_rd(4'h4, s);
    chk("R3 zero length does not arm", s, 32'h0);
    @(negedge clk);
    chk("R4 tready low when not armed", {31'd0, tready}, 32'd0);
    lite_wr(4'h0, 32'h0);
    lite_rd(4'h4, s);
    chk("R2 halted sets when run cleared", s, 32'h1);
    lite_wr(4'h8, 32'h100);
    lite_wr(4'hC, 32'd64);
    lite_rd(4'h4, s);
    chk("R3 length write while halted does not arm", s, 32'h1);
    lite_wr(4'h0, 32'h1);
  endtask

  task automatic t_basic();
    logic [31:0] s;
    lite_wr(4'h8, 32'h103);
    lite_rd(4'h8, s);
    chk("R5 destination low bits forced to zero", s, 32'h100);
    lite_wr(4'hC, 32'd64);
    lite_rd(4'h4, s);
    chk("R3 nonzero length arms (busy)", s, 32'h2);
    lite_wr(4'hC, 32'd4);   // busy: must be ignored
    @(negedge clk);
    chk("R4 tready high when armed", {31'd0, tready}, 32'd1);
    send_pkt(1, 5, 4'h3);
    @(negedge clk);
    chk("R4 tready low after tlast", {31'd0, tready}, 32'd0);
    wait_done();
    lite_rd(4'h4, s);
    chk("R3/R8 done, no error, not busy", s, 32'h10);
    lite_rd(4'hC, s);
    chk("R8 length reads bytes stored", s, 32'd18);
    check_mem("R5 data at destination", 32'h100, 18, 1);
    chk("R7 bytes past final tkeep untouched", {24'd0, mem[32'h112]}, 32'hEE);
    chk("R10 done irq masked when disabled", {31'd0, done_irq}, 32'd0);
    lite_wr(4'h4, 32'h10);
    lite_rd(4'h4, s);
    chk("R10 done cleared by write one", s, 32'h0);
  endtask

  task automatic t_page();
    logic [31:0] s;
    int b0;
    b0 = n_bursts;
    lite_wr(4'h0, 32'h3);
    lite_wr(4'h8, 32'hFF0);
    lite_wr(4'hC, 32'd200);
    send_pkt(2, 20, 4'hF);
    wait_done();
    @(negedge clk);
    chk("R10 done irq when enabled", {31'd0, done_irq}, 32'd1);
    chk("R6 split into 4+16 beat bursts", 32'(n_bursts - b0), 32'd2);
    lite_rd(4'hC, s);
    chk("R8 length after page split", s, 32'd80);
    check_mem("R5 data across page", 32'hFF0, 80, 2);
    lite_wr(4'h4, 32'h10);
  endtask

  task automatic t_overflow();
    logic [31:0] s;
    lite_wr(4'h0, 32'h5);
    lite_wr(4'h8, 32'h400);
    lite_wr(4'hC, 32'd10);
    send_pkt(3, 6, 4'hF);
    wait_done();
    lite_rd(4'h4, s);
    chk("R9 error and done set on overflow", s, 32'h30);
    lite_rd(4'hC, s);
    chk("R9 length reports bytes stored", s, 32'd10);
    check_mem("R9 data inside buffer", 32'h400, 10, 3);
    chk("R7 capacity-trimmed strobes", {24'd0, mem[32'h40A]}, 32'hEE);
    chk("R9 nothing past buffer", {24'd0, mem[32'h410]}, 32'hEE);
    @(negedge clk);
    chk("R10 irqs independent", {30'd0, done_irq, err_irq}, 32'h1);
    lite_wr(4'h4, 32'h30);
    @(negedge clk);
    chk("R10 irqs drop after clear", {30'd0, done_irq, err_irq}, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] s;
    lite_wr(4'h8, 32'h600);
    lite_wr(4'hC, 32'd4);
    send_beat(word_of(4, 0), 4'hF, 1'b0);
    @(negedge clk);
    cfg_awaddr = 4'h4; cfg_wdata = 32'h20; cfg_awvalid = 1; cfg_wvalid = 1;
    tdata = word_of(4, 1); tkeep = 4'hF; tlast = 1; tvalid = 1;
    #1;
    chk("R10 both handshakes on one edge", {30'd0, cfg_awready, tready}, 32'h3);
    @(posedge clk); #1;
    cfg_awvalid = 0; cfg_wvalid = 0; tvalid = 0; tlast = 0;
    wait_done();
    lite_rd(4'h4, s);
    chk("R10 set wins over same-cycle clear", s, 32'h30);
    check_mem("R9 single kept beat", 32'h600, 4, 4);
    chk("R9 discarded beat not written", {24'd0, mem[32'h604]}, 32'hEE);
    lite_wr(4'h4, 32'h20);
    lite_rd(4'h4, s);
    chk("R10 later clear of error", s, 32'h10);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'hEE;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_run_and_zero_len();
    t_basic();
    t_page();
    t_overflow();
    t_collision();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule